// File: doc/BRIEF.md
# Run-Time Selectable Branch Direction Predictor

This block sits beside a fetch stage and chooses the next fetch address. Each cycle it is given the current fetch address, a flag saying that decode has found a branch there, the branch's four-bit class code and the branch's target address. It returns a taken or not-taken guess and the address to fetch next. That address is the branch target when the guess is taken. Otherwise it is the sequential address, which is the fetch address plus the instruction size. Both outputs are combinational, so the fetch stage can use them in the same cycle.

A two-bit policy input picks one of four schemes at run time:
- never jump;
- always jump;
- a fixed guess per class code, read from a 16-bit mask register;
- a learned guess from a table of 2-bit saturating counters.

The pipeline reports each branch outcome later through a resolve port. This port carries the branch address, the actual direction, the guess that was made at fetch and the target. Every resolve trains the counter table. A resolve whose actual direction differs from the guess produces a one-cycle redirect pulse, together with the address the fetch stage must restart from.

Top module: `fetch_dir_predictor`

## Requirements
- R1: When `fetch_is_br_i` is 0, `pred_taken_o` is 0 and `next_pc_o` equals `fetch_pc_i + 4` under every policy.
- R2: With `policy_i` = 2'b00 (never), a branch gives `pred_taken_o` = 0 and `next_pc_o` = `fetch_pc_i + 4`.
- R3: With `policy_i` = 2'b01 (always), a branch gives `pred_taken_o` = 1 and `next_pc_o` = `fetch_tgt_i`.
- R4: With `policy_i` = 2'b10 (class), a branch gives `pred_taken_o` equal to bit `fetch_cls_i` of the class mask, and `next_pc_o` follows that guess.
- R5: With `policy_i` = 2'b11 (history), a branch uses the counter selected by `fetch_pc_i[5:2]`. Counter values 2 and 3 predict taken; values 0 and 1 predict not taken.
- R6: A clock edge with `res_valid_i` = 1 moves the counter selected by `res_pc_i[5:2]` one step toward `res_taken_i`. The counter saturates at 0 and 3. Training happens under every policy, and the new value is used from the following cycle.
- R7: After reset, every counter holds 1, the class mask holds 16'h0000 and `mispredict_o` is 0.
- R8: A clock edge with `cfg_we_i` = 1 loads `cfg_mask_i` into the class mask. The new mask is used from the following cycle.
- R9: `mispredict_o` is 1 for exactly the cycle after an edge at which `res_valid_i` = 1 and `res_taken_i` differs from `res_pred_i`; it is 0 in all other cycles.
- R10: While `mispredict_o` is 1, `fix_pc_o` equals the resolved `res_tgt_i` if the branch was taken, and otherwise the resolved `res_pc_i + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Prediction policy select |
| cfg_we_i | input | 1 | Class mask write enable |
| cfg_mask_i | input | 16 | Class mask write data |
| fetch_pc_i | input | 32 | Current fetch address |
| fetch_is_br_i | input | 1 | Decode marks a branch at this address |
| fetch_cls_i | input | 4 | Branch class code |
| fetch_tgt_i | input | 32 | Branch target address |
| pred_taken_o | output | 1 | Guessed direction |
| next_pc_o | output | 32 | Next fetch address |
| res_valid_i | input | 1 | Resolved outcome present |
| res_pc_i | input | 32 | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_pred_i | input | 1 | Direction guessed at fetch |
| res_tgt_i | input | 32 | Target of the resolved branch |
| mispredict_o | output | 1 | One-cycle redirect pulse |
| fix_pc_o | output | 32 | Restart address during the pulse |

## Verification
The bench drives several outcomes in a row at one table index, in both directions, to reach both saturation limits. A counter that wrapped instead of saturating would flip its guess after the fourth same-direction outcome.

It also fetches and resolves the same index in a single cycle. A design that bypassed the new counter value into that cycle's guess would answer one cycle early.

Mask writes are followed at once by class-policy fetches, which catches a mask used before its edge or at the wrong bit position. Mispredicts in both directions confirm that the restart address is the target when the branch was taken and the sequential address when it was not. Non-branch fetches under the always policy must still go sequential.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
   typedef enum logic [1:0] {
      POL_NEVER   = 2'b00,
      POL_ALWAYS  = 2'b01,
      POL_CLASS   = 2'b10,
      POL_HISTORY = 2'b11
   } policy_e;
endpackage

// File: rtl/fdp_cfg_reg.sv
module fdp_cfg_reg #(
   parameter int          WIDTH = 16,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= INIT;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/fdp_static_policy.sv
module fdp_static_policy
   import fdp_pkg::*;
#(
   parameter int CLS_W  = 4,
   localparam int N_CLS = 1 << CLS_W
) (
   input  policy_e          policy,
   input  logic [CLS_W-1:0] cls,
   input  logic [N_CLS-1:0] mask,
   output logic             take
);
   always_comb begin
      unique case (policy)
         POL_NEVER:  take = 1'b0;
         POL_ALWAYS: take = 1'b1;
         POL_CLASS:  take = mask[cls];
         default:    take = 1'b0;
      endcase
   end
endmodule

// File: rtl/fdp_hist_table.sv
module fdp_hist_table #(
   parameter int IDX_BITS = 4,
   parameter int CNT_W    = 2,
   parameter int CNT_INIT = 1,
   localparam int N_ENT   = 1 << IDX_BITS,
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_BITS-1:0] rd_idx,
   output logic                rd_taken,
   input  logic                wr_en,
   input  logic [IDX_BITS-1:0] wr_idx,
   input  logic                wr_taken
);
   logic [CNT_W-1:0] cnt [N_ENT];

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_BITS'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt[e] <= CNT_W'(CNT_INIT);
         end else if (hit) begin
            if (wr_taken && cnt[e] != CNT_MAX)
               cnt[e] <= cnt[e] + 1'b1;
            else if (!wr_taken && cnt[e] != '0)
               cnt[e] <= cnt[e] - 1'b1;
         end
      end
   end

   // upper half of the counter range means taken
   assign rd_taken = cnt[rd_idx][CNT_W-1];
endmodule

// File: rtl/fdp_resolve.sv
module fdp_resolve #(
   parameter int ADDR_W      = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic              res_pred,
   input  logic [ADDR_W-1:0] res_tgt,
   output logic              mispredict,
   output logic [ADDR_W-1:0] fix_pc
);
   logic              wrong;
   logic [ADDR_W-1:0] restart;

   assign wrong   = res_valid && (res_taken != res_pred);
   assign restart = res_taken ? res_tgt : res_pc + ADDR_W'(INSTR_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mispredict <= 1'b0;
         fix_pc     <= '0;
      end else begin
         mispredict <= wrong;
         if (wrong) fix_pc <= restart;
      end
   end
endmodule

// File: rtl/fetch_dir_predictor.sv
module fetch_dir_predictor
   import fdp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int INSTR_BYTES = 4,
   parameter int CLS_W       = 4,
   parameter int IDX_BITS    = 4,
   parameter int CNT_W       = 2,
   parameter int CNT_INIT    = 1,
   parameter logic [(1<<CLS_W)-1:0] MASK_INIT = '0,
   localparam int IDX_LO     = $clog2(INSTR_BYTES),
   localparam int N_CLS      = 1 << CLS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy_i,
   input  logic              cfg_we_i,
   input  logic [N_CLS-1:0]  cfg_mask_i,
   input  logic [ADDR_W-1:0] fetch_pc_i,
   input  logic              fetch_is_br_i,
   input  logic [CLS_W-1:0]  fetch_cls_i,
   input  logic [ADDR_W-1:0] fetch_tgt_i,
   output logic              pred_taken_o,
   output logic [ADDR_W-1:0] next_pc_o,
   input  logic              res_valid_i,
   input  logic [ADDR_W-1:0] res_pc_i,
   input  logic              res_taken_i,
   input  logic              res_pred_i,
   input  logic [ADDR_W-1:0] res_tgt_i,
   output logic              mispredict_o,
   output logic [ADDR_W-1:0] fix_pc_o
);
   // elaboration-time parameter checks
   if (IDX_LO + IDX_BITS > ADDR_W) begin : g_bad_idx
      $error("history index runs past the address width");
   end
   if ((1 << IDX_LO) != INSTR_BYTES) begin : g_bad_isz
      $error("instruction size must be a power of two");
   end
   if (CNT_W < 1 || CNT_INIT < 0 || CNT_INIT >= (1 << CNT_W)) begin : g_bad_cnt
      $error("counter width or initial value out of range");
   end

   policy_e              policy;
   logic [N_CLS-1:0]     cls_mask_q;
   logic                 static_take;
   logic                 hist_take;
   logic                 take;
   logic [ADDR_W-1:0]    seq_pc;

   assign policy = policy_e'(policy_i);
   assign seq_pc = fetch_pc_i + ADDR_W'(INSTR_BYTES);

   fdp_cfg_reg #(.WIDTH(N_CLS), .INIT(MASK_INIT)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we_i),
      .wdata (cfg_mask_i),
      .q     (cls_mask_q)
   );

   fdp_static_policy #(.CLS_W(CLS_W)) u_static (
      .policy (policy),
      .cls    (fetch_cls_i),
      .mask   (cls_mask_q),
      .take   (static_take)
   );

   fdp_hist_table #(
      .IDX_BITS (IDX_BITS),
      .CNT_W    (CNT_W),
      .CNT_INIT (CNT_INIT)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fetch_pc_i[IDX_LO +: IDX_BITS]),
      .rd_taken (hist_take),
      .wr_en    (res_valid_i),
      .wr_idx   (res_pc_i[IDX_LO +: IDX_BITS]),
      .wr_taken (res_taken_i)
   );

   always_comb begin
      if (!fetch_is_br_i)              take = 1'b0;
      else if (policy == POL_HISTORY)  take = hist_take;
      else                             take = static_take;
   end

   assign pred_taken_o = take;
   assign next_pc_o    = take ? fetch_tgt_i : seq_pc;

   fdp_resolve #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid_i),
      .res_pc     (res_pc_i),
      .res_taken  (res_taken_i),
      .res_pred   (res_pred_i),
      .res_tgt    (res_tgt_i),
      .mispredict (mispredict_o),
      .fix_pc     (fix_pc_o)
   );
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
   parameter int ADDR_W      = 32,
   parameter int INSTR_BYTES = 4,
   parameter int CLS_W       = 4,
   localparam int N_CLS      = 1 << CLS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        policy_i,
   input logic [N_CLS-1:0]  cls_mask_q,
   input logic [ADDR_W-1:0] fetch_pc_i,
   input logic              fetch_is_br_i,
   input logic [CLS_W-1:0]  fetch_cls_i,
   input logic [ADDR_W-1:0] fetch_tgt_i,
   input logic              pred_taken_o,
   input logic [ADDR_W-1:0] next_pc_o,
   input logic              res_valid_i,
   input logic [ADDR_W-1:0] res_pc_i,
   input logic              res_taken_i,
   input logic              res_pred_i,
   input logic [ADDR_W-1:0] res_tgt_i,
   input logic              mispredict_o,
   input logic [ADDR_W-1:0] fix_pc_o
);
   AST_NONBR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_is_br_i |-> (!pred_taken_o && next_pc_o == fetch_pc_i + ADDR_W'(INSTR_BYTES))); // R1
   AST_NEVER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'b00) |-> !pred_taken_o); // R2
   AST_ALWAYS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'b01 && fetch_is_br_i) |-> (pred_taken_o && next_pc_o == fetch_tgt_i)); // R3
   AST_CLASS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'b10 && fetch_is_br_i) |-> (pred_taken_o == cls_mask_q[fetch_cls_i])); // R4
   AST_MP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && res_taken_i != res_pred_i) |=> mispredict_o); // R9
   AST_MP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid_i && res_taken_i != res_pred_i) |=> !mispredict_o); // R9
   AST_FIX_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && res_taken_i != res_pred_i) |=>
         (fix_pc_o == ($past(res_taken_i) ? $past(res_tgt_i)
                                          : $past(res_pc_i) + ADDR_W'(INSTR_BYTES)))); // R10
endmodule

bind fetch_dir_predictor fdp_checker #(
   .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES), .CLS_W(CLS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .cls_mask_q(cls_mask_q),
   .fetch_pc_i(fetch_pc_i), .fetch_is_br_i(fetch_is_br_i), .fetch_cls_i(fetch_cls_i),
   .fetch_tgt_i(fetch_tgt_i), .pred_taken_o(pred_taken_o), .next_pc_o(next_pc_o),
   .res_valid_i(res_valid_i), .res_pc_i(res_pc_i), .res_taken_i(res_taken_i),
   .res_pred_i(res_pred_i), .res_tgt_i(res_tgt_i), .mispredict_o(mispredict_o),
   .fix_pc_o(fix_pc_o)
);

// File: tb/fetch_dir_predictor_test.sv
`timescale 1ns/1ps
module fetch_dir_predictor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  policy_i = '0;
   logic        cfg_we_i = 1'b0;
   logic [15:0] cfg_mask_i = '0;
   logic [31:0] fetch_pc_i = '0;
   logic        fetch_is_br_i = 1'b0;
   logic [3:0]  fetch_cls_i = '0;
   logic [31:0] fetch_tgt_i = '0;
   logic        pred_taken_o;
   logic [31:0] next_pc_o;
   logic        res_valid_i = 1'b0;
   logic [31:0] res_pc_i = '0;
   logic        res_taken_i = 1'b0;
   logic        res_pred_i = 1'b0;
   logic [31:0] res_tgt_i = '0;
   logic        mispredict_o;
   logic [31:0] fix_pc_o;

   always #4 clk = ~clk;

   fetch_dir_predictor uut (.*);

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state, built from the requirements
   int          m_cnt [16];
   logic [15:0] m_mask;
   logic        exp_mp;
   logic [31:0] exp_fix;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_take(input logic [1:0] pol, input logic br,
                                     input logic [3:0] cls, input logic [31:0] pc);
      if (!br) return 1'b0;                       // R1
      case (pol)
         2'b00:   return 1'b0;                    // R2
         2'b01:   return 1'b1;                    // R3
         2'b10:   return m_mask[cls];             // R4
         default: return m_cnt[pc[5:2]] >= 2;     // R5
      endcase
   endfunction

   task automatic run_cycle(input logic [1:0] pol, input logic we, input logic [15:0] wmask,
                            input logic [31:0] pc, input logic br, input logic [3:0] cls,
                            input logic [31:0] tgt, input logic rv, input logic [31:0] rpc,
                            input logic rt, input logic rp, input logic [31:0] rtgt);
      logic t;
      logic [31:0] np;
      @(negedge clk);
      check(mispredict_o == exp_mp, "R9 mispredict", 32'(mispredict_o), 32'(exp_mp));
      if (exp_mp) check(fix_pc_o == exp_fix, "R10 fix_pc", fix_pc_o, exp_fix);
      policy_i = pol; cfg_we_i = we; cfg_mask_i = wmask;
      fetch_pc_i = pc; fetch_is_br_i = br; fetch_cls_i = cls; fetch_tgt_i = tgt;
      res_valid_i = rv; res_pc_i = rpc; res_taken_i = rt; res_pred_i = rp; res_tgt_i = rtgt;
      #1;
      t  = exp_take(pol, br, cls, pc);
      np = t ? tgt : pc + 32'd4;
      if (!br)
         check(pred_taken_o == 1'b0 && next_pc_o == np, "R1 non-branch", next_pc_o, np);
      else if (pol == 2'b11)
         check(pred_taken_o == t && next_pc_o == np, "R5/R6 history guess", {31'b0, pred_taken_o}, {31'b0, t});
      else
         check(pred_taken_o == t && next_pc_o == np, "R2/R3/R4 static guess", next_pc_o, np);
      exp_mp  = rv && (rt != rp);
      exp_fix = rt ? rtgt : rpc + 32'd4;
      if (rv) begin
         if (rt && m_cnt[rpc[5:2]] < 3) m_cnt[rpc[5:2]]++;
         else if (!rt && m_cnt[rpc[5:2]] > 0) m_cnt[rpc[5:2]]--;
      end
      if (we) m_mask = wmask;
   endtask

   function automatic logic [31:0] pc_at(input int idx, input logic [31:0] hi);
      return {hi[31:6], idx[3:0], 2'b00};
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      foreach (m_cnt[i]) m_cnt[i] = 1;
      m_mask = 16'h0000;
      exp_mp = 1'b0; exp_fix = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R7: reset state, every index predicts not taken, mask clear
      for (int i = 0; i < 16; i++)
         run_cycle(2'b11, 0, 0, pc_at(i, 32'h1000_0000), 1, 4'(i), 32'h2000_0000 + 32'(i), 0, 0, 0, 0, 0);
      for (int c = 0; c < 16; c++)
         run_cycle(2'b10, 0, 0, 32'h400, 1, 4'(c), 32'h800, 0, 0, 0, 0, 0);

      // R3 with R1: non-branch under always policy goes sequential
      run_cycle(2'b01, 0, 0, 32'h100, 0, 0, 32'h900, 0, 0, 0, 0, 0);
      run_cycle(2'b01, 0, 0, 32'h100, 1, 0, 32'h900, 0, 0, 0, 0, 0);

      // R8: mask write then immediate use
      run_cycle(2'b10, 1, 16'h8421, 32'h200, 1, 4'd0, 32'h300, 0, 0, 0, 0, 0);
      run_cycle(2'b10, 0, 0, 32'h200, 1, 4'd0, 32'h300, 0, 0, 0, 0, 0);
      run_cycle(2'b10, 0, 0, 32'h200, 1, 4'd5, 32'h300, 0, 0, 0, 0, 0);
      run_cycle(2'b10, 0, 0, 32'h200, 1, 4'd15, 32'h300, 0, 0, 0, 0, 0);

      // R6: saturate up at index 5, fetching the same index each cycle
      for (int k = 0; k < 5; k++)
         run_cycle(2'b11, 0, 0, pc_at(5, 32'h3000_0000), 1, 0, 32'h44,
                   1, pc_at(5, 32'h5000_0000), 1, 0, 32'h6600);
      // R6: saturate down, mispredicting as not taken
      for (int k = 0; k < 5; k++)
         run_cycle(2'b11, 0, 0, pc_at(5, 32'h3000_0000), 1, 0, 32'h44,
                   1, pc_at(5, 32'h5000_0040), 0, 1, 32'h6600);
      run_cycle(2'b11, 0, 0, pc_at(5, 32'h3000_0000), 1, 0, 32'h44, 0, 0, 0, 0, 0);

      // R6: training also happens under never policy
      for (int k = 0; k < 2; k++)
         run_cycle(2'b00, 0, 0, pc_at(9, 0), 1, 0, 32'h70, 1, pc_at(9, 32'h40), 1, 1, 32'h80);
      run_cycle(2'b11, 0, 0, pc_at(9, 0), 1, 0, 32'h70, 0, 0, 0, 0, 0);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic [1:0] pol = 2'($urandom_range(0, 3));
         logic we = ($urandom_range(0, 15) == 0);
         run_cycle(pol, we, 16'($urandom),
                   {$urandom} & 32'hFFFF_FFFC, ($urandom_range(0, 3) != 0),
                   4'($urandom), {$urandom} & 32'hFFFF_FFFC,
                   $urandom_range(0, 1) == 1, pc_at($urandom_range(0, 15), $urandom),
                   $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                   {$urandom} & 32'hFFFF_FFFC);
      end
      run_cycle(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule